// File: doc/BRIEF.md
# Tape block keyword search unit

This unit follows a stream of frames read from a tape and locates a target block on its own, without help from the processor. Every frame carries one BCD digit, a parity bit and a control bit; a frame with the control bit set is a block boundary. Machine words are written as twelve digits plus one spacer frame, and a block holds ten or more words.

Two operations are offered. A keyword search treats the first word of each block as an unsigned decimal keyword. It stops at the first block whose keyword is not below the target, and it can run with the tape moving forward or backward. A scan runs forward only and stops when one of the first ten words of a block equals the target. When the unit stops, it reports a found pulse and the number of blocks passed. A parity failure or a badly formed block ends the operation with a sticky error flag, and no found pulse is given.

Top module: `tape_key_seek`

## Requirements
- R1: A frame is good when its six bits (control, parity, four digit bits) hold an even number of ones. A bad frame seen while busy sets `par_err`, pulses `done` one cycle later with `found` low, and returns the unit to idle.
- R2: `start` in idle latches the operation, the direction and the target, clears `blk_cnt`, `par_err` and `fmt_err`, and raises `busy`. All frames before the first boundary frame are ignored.
- R3: A word is 13 frames. Forward: twelve digits, most significant first, then a spacer. Reverse: a spacer, then twelve digits, least significant first.
- R4: Forward search (`op_scan`=0, `dir_rev`=0) stops at the first block whose first word, read as a 12-digit unsigned decimal number, is greater than or equal to `target`. `done` and `found` pulse one cycle after the spacer frame of that word.
- R5: Reverse search (`op_scan`=0, `dir_rev`=1) treats the last word before each boundary as the keyword. It steps over blocks whose keyword is greater than or equal to `target`. It stops with `found` at the boundary that closes the first block whose keyword is below `target`.
- R6: Scan (`op_scan`=1) stops with `found` at the spacer of the first word, among word positions 0 to 9 of a block, that equals `target`. Words from position 10 on never match, and `dir_rev` has no effect.
- R7: `blk_cnt` counts the blocks passed without a stop, incrementing at each closing boundary (16 bits). It holds its value after the stop.
- R8: A boundary that arrives mid-word, or that closes a block of fewer than 10 words, sets `fmt_err` and pulses `done` with `found` low.
- R9: `done` lasts one cycle. `found` is only high together with `done`, and `busy` is low after `done`.
- R10: While idle, frames change neither `blk_cnt` nor `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted in idle) |
| op_scan | input | 1 | 1 = equality scan, 0 = keyword search |
| dir_rev | input | 1 | 1 = tape moving backward (search only) |
| target | input | 48 | Target value, 12 BCD digits |
| frame_vld | input | 1 | A frame is present this cycle |
| frame_dig | input | 4 | BCD digit of the frame |
| frame_par | input | 1 | Parity bit of the frame |
| frame_ctl | input | 1 | Block-boundary control bit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle stop pulse |
| found | output | 1 | Target located (with done) |
| blk_cnt | output | 16 | Blocks passed |
| par_err | output | 1 | Sticky parity failure |
| fmt_err | output | 1 | Sticky malformed-block flag |

## Verification
On every cycle, the assertions check these rules: the parity abort and its one-cycle timing, the stop pulse shape, the clearing at start, that the count moves by at most one, and that nothing changes while idle. Other behaviour depends on the meaning of whole frame sequences, and only the bench scenarios can show it: which block satisfies the keyword order, digit precedence, the reverse rule that equal keywords are stepped over, the scan window of ten words, and the blocks counted before a stop. Those scenarios compare results with models that work on the bench's own copy of the tape contents.

// File: rtl/tape_key_seek.sv
module tape_key_seek #(
  parameter int DIGITS = 12,
  parameter int MINW   = 10,
  parameter int SCANW  = 10,
  parameter int CNTW   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  op_scan,
  input  logic                  dir_rev,
  input  logic [4*DIGITS-1:0]   target,
  input  logic                  frame_vld,
  input  logic [3:0]            frame_dig,
  input  logic                  frame_par,
  input  logic                  frame_ctl,
  output logic                  busy,
  output logic                  done,
  output logic                  found,
  output logic [CNTW-1:0]       blk_cnt,
  output logic                  par_err,
  output logic                  fmt_err
);
  localparam int PW = $clog2(DIGITS + 1);
  localparam int WW = 7;
  localparam logic [PW-1:0] LASTP = PW'(DIGITS);
  localparam logic [WW-1:0] MINW_V = WW'(MINW);
  localparam logic [WW-1:0] SCAN_V = WW'(SCANW);
  localparam logic [1:0] C_EQ = 2'b00, C_GT = 2'b01, C_LT = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_SYNC, S_RUN} st_t;
  st_t st;

  logic [4*DIGITS-1:0] tgt_q;
  logic scan_q, rev_q, last_ge;
  logic [PW-1:0] pos, didx;
  logic [WW-1:0] widx;
  logic [1:0] cmp, cmp_nx;
  logic [3:0] tdig;
  logic par_bad, is_digit, word_end, ge, hit;

  assign busy     = (st != S_IDLE);
  assign par_bad  = ^{frame_ctl, frame_par, frame_dig};
  assign is_digit = rev_q ? (pos != '0) : (pos != LASTP);
  assign word_end = (pos == LASTP);
  assign didx     = !is_digit ? '0 : rev_q ? pos - 1'b1 : LASTP - 1'b1 - pos;
  assign tdig     = tgt_q[{didx, 2'b00} +: 4];

  always_comb begin
    cmp_nx = cmp;
    if (is_digit && frame_dig != tdig && (rev_q || cmp == C_EQ))
      cmp_nx = (frame_dig > tdig) ? C_GT : C_LT;
  end

  assign ge  = (cmp_nx != C_LT);
  assign hit = scan_q ? (widx < SCAN_V && cmp_nx == C_EQ) : (!rev_q && widx == '0 && ge);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; tgt_q <= '0; scan_q <= 1'b0; rev_q <= 1'b0; last_ge <= 1'b0;
      pos <= '0; widx <= '0; cmp <= C_EQ; done <= 1'b0; found <= 1'b0;
      blk_cnt <= '0; par_err <= 1'b0; fmt_err <= 1'b0;
    end else begin
      done  <= 1'b0;
      found <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          st <= S_SYNC; tgt_q <= target; scan_q <= op_scan; rev_q <= dir_rev & ~op_scan;
          blk_cnt <= '0; par_err <= 1'b0; fmt_err <= 1'b0;
        end
      end else if (frame_vld) begin
        if (par_bad) begin
          par_err <= 1'b1; done <= 1'b1; st <= S_IDLE;
        end else if (frame_ctl) begin
          pos <= '0; widx <= '0; cmp <= C_EQ;
          if (st == S_SYNC) st <= S_RUN;
          else if (pos != '0 || widx < MINW_V) begin
            fmt_err <= 1'b1; done <= 1'b1; st <= S_IDLE;
          end else if (rev_q && !last_ge) begin
            found <= 1'b1; done <= 1'b1; st <= S_IDLE;
          end else blk_cnt <= blk_cnt + 1'b1;
        end else if (st == S_RUN) begin
          if (word_end) begin
            pos <= '0; cmp <= C_EQ; last_ge <= ge;
            if (widx != '1) widx <= widx + 1'b1;
            if (hit) begin
              found <= 1'b1; done <= 1'b1; st <= S_IDLE;
            end
          end else begin
            pos <= pos + 1'b1; cmp <= cmp_nx;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tape_key_seek_chk.sv
module tape_key_seek_chk #(
  parameter int CNTW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            frame_vld,
  input logic [3:0]      frame_dig,
  input logic            frame_par,
  input logic            frame_ctl,
  input logic            busy,
  input logic            done,
  input logic            found,
  input logic [CNTW-1:0] blk_cnt,
  input logic            par_err,
  input logic            fmt_err
);
  p_parity_abort_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy && frame_vld && (^{frame_ctl, frame_par, frame_dig}) |=> done && par_err && !found && !busy);

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy && blk_cnt == '0 && !par_err && !fmt_err);

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (blk_cnt == $past(blk_cnt)) || (blk_cnt == $past(blk_cnt) + 1'b1));

  p_fmt_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fmt_err) |-> done && !found);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done);

  p_found_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> done && !par_err && !fmt_err);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(blk_cnt) && !done);
endmodule

bind tape_key_seek tape_key_seek_chk #(.CNTW(CNTW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .frame_vld(frame_vld),
  .frame_dig(frame_dig), .frame_par(frame_par), .frame_ctl(frame_ctl),
  .busy(busy), .done(done), .found(found), .blk_cnt(blk_cnt),
  .par_err(par_err), .fmt_err(fmt_err));

// File: tb/tape_key_seek_tb_top.sv
module tape_key_seek_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, op_scan = 1'b0, dir_rev = 1'b0;
  logic [47:0] target = '0;
  logic frame_vld = 1'b0, frame_par = 1'b0, frame_ctl = 1'b0;
  logic [3:0] frame_dig = '0;
  logic busy, done, found, par_err, fmt_err;
  logic [15:0] blk_cnt;

  tape_key_seek dut_i (.clk(clk), .rst_n(rst_n), .start(start), .op_scan(op_scan),
    .dir_rev(dir_rev), .target(target), .frame_vld(frame_vld), .frame_dig(frame_dig),
    .frame_par(frame_par), .frame_ctl(frame_ctl), .busy(busy), .done(done),
    .found(found), .blk_cnt(blk_cnt), .par_err(par_err), .fmt_err(fmt_err));

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [47:0] tw [0:7][0:15];
  int nw [0:7];
  int nb = 0, fidx = 0, par_at = -1, cut_blk = -1;
  bit seen_done = 0, g_found = 0, g_pe = 0, g_fe = 0;
  int g_cnt = 0;

  task automatic check(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic logic [47:0] rand_word();
    logic [47:0] w;
    for (int i = 0; i < 12; i++) w[4*i +: 4] = 4'($urandom % 10);
    return w;
  endfunction

  function automatic void fill(int b, int n);
    nw[b] = n;
    for (int w = 0; w < 16; w++) tw[b][w] = rand_word();
  endfunction

  function automatic int m_fwd(logic [47:0] t);
    for (int b = 0; b < nb; b++) if (tw[b][0] >= t) return b;
    return -1;
  endfunction

  function automatic int m_rev(logic [47:0] t);
    for (int b = 0; b < nb; b++) if (tw[b][0] < t) return b;
    return -1;
  endfunction

  function automatic int m_scan(logic [47:0] t);
    for (int b = 0; b < nb; b++)
      for (int w = 0; w < 10 && w < nw[b]; w++) if (tw[b][w] == t) return b;
    return -1;
  endfunction

  task automatic send(logic c, logic [3:0] d);
    if (seen_done) return;
    frame_vld = 1'b1; frame_ctl = c; frame_dig = d;
    frame_par = (^{c, d}) ^ (fidx == par_at);
    fidx++;
    @(negedge clk);
    frame_vld = 1'b0;
    if (done) begin
      seen_done = 1; g_found = found; g_cnt = blk_cnt; g_pe = par_err; g_fe = fmt_err;
    end
  endtask

  // R3: forward = MSD first then spacer, reverse = spacer then LSD first
  task automatic emit_word(logic [47:0] w, bit rev, int lim);
    if (!rev) begin
      for (int i = 11; i >= 0 && (11 - i) < lim; i--) send(1'b0, w[4*i +: 4]);
      if (lim > 12) send(1'b0, 4'd0);
    end else begin
      send(1'b0, 4'd0);
      for (int i = 0; i < 12 && i + 1 < lim; i++) send(1'b0, w[4*i +: 4]);
    end
  endtask

  task automatic emit_tape(bit rev);
    send(1'b1, 4'd0);
    for (int b = 0; b < nb; b++) begin
      if (b == cut_blk) emit_word(tw[b][0], rev, 5);
      else if (!rev) for (int w = 0; w < nw[b]; w++) emit_word(tw[b][w], 0, 13);
      else for (int w = nw[b] - 1; w >= 0; w--) emit_word(tw[b][w], 1, 13);
      send(1'b1, 4'd0);
    end
  endtask

  task automatic run_op(string tag, bit scan, bit rev, logic [47:0] t, int junk,
                        bit xf, int xcnt, bit xpe, bit xfe);
    op_scan = scan; dir_rev = rev; target = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R2 busy after start"}, busy, 1);
    check({tag, " R2 count cleared"}, blk_cnt, 0);
    seen_done = 0; fidx = 0;
    for (int j = 0; j < junk; j++) send(1'b0, 4'($urandom % 10));
    emit_tape(rev && !scan);
    check({tag, " R9 stop seen"}, seen_done, 1);
    check({tag, " R4/R5/R6 found"}, g_found, xf);
    check({tag, " R7 blk_cnt"}, g_cnt, xcnt);
    check({tag, " R1 par_err"}, g_pe, xpe);
    check({tag, " R8 fmt_err"}, g_fe, xfe);
    check({tag, " R9 idle after stop"}, busy, 0);
    par_at = -1; cut_blk = -1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset busy", busy, 0);
    check("reset done", done, 0);
    check("reset blk_cnt", blk_cnt, 0);
    check("reset flags", {par_err, fmt_err, found}, 0);

    // R4: equal keyword stops forward search
    nb = 4;
    for (int b = 0; b < nb; b++) fill(b, 10 + b);
    tw[0][0] = 48'h100; tw[1][0] = 48'h200; tw[2][0] = 48'h300; tw[3][0] = 48'h400;
    run_op("R4 equal", 0, 0, 48'h300, 0, 1, 2, 0, 0);

    // R4: digit precedence, MSD decides
    tw[0][0] = 48'h049999999999; tw[1][0] = 48'h050000000000;
    run_op("R4 msd", 0, 0, 48'h050000000000, 0, 1, 1, 0, 0);

    // R5: equal keyword stepped over in reverse, stop on first lower
    tw[0][0] = 48'h500; tw[1][0] = 48'h400; tw[2][0] = 48'h300; tw[3][0] = 48'h200;
    run_op("R5 reverse", 0, 1, 48'h300, 0, 1, 3, 0, 0);

    // R6: word 10 ignored, dir_rev ignored in scan
    nb = 2; fill(0, 12); fill(1, 12);
    tw[0][10] = 48'h777; tw[1][9] = 48'h777;
    run_op("R6 scan window", 1, 1, 48'h777, 0, 1, 1, 0, 0);

    // R2: junk before first boundary is ignored
    nb = 3; for (int b = 0; b < nb; b++) fill(b, 10);
    tw[0][0] = 48'h0; tw[1][0] = 48'h0; tw[2][0] = 48'h999999999999;
    run_op("R2 sync", 0, 0, 48'h999999999999, 7, 1, 2, 0, 0);

    // R8: short block
    nb = 3; fill(0, 10); fill(1, 9); fill(2, 10);
    tw[0][0] = 48'h0; tw[1][0] = 48'h0; tw[2][0] = 48'h999999999999;
    run_op("R8 short", 0, 0, 48'h999999999999, 0, 0, 1, 0, 1);

    // R8: boundary mid-word
    fill(1, 10); tw[1][0] = 48'h0; cut_blk = 1;
    run_op("R8 midword", 0, 0, 48'h999999999999, 0, 0, 1, 0, 1);

    // R1: parity error aborts
    par_at = 40;
    run_op("R1 parity", 0, 0, 48'h999999999999, 0, 0, 0, 1, 0);

    // R10: frames while idle are ignored
    seen_done = 0;
    for (int j = 0; j < 30; j++) send(1'(j % 13 == 0), 4'(j % 10));
    check("R10 no done idle", seen_done, 0);
    check("R10 blk_cnt held", blk_cnt, 0);
    check("R10 still idle", busy, 0);

    // random operations
    void'($urandom(32'd4242));
    for (int it = 0; it < 12; it++) begin
      int md, xb;
      logic [47:0] t;
      nb = 2 + ($urandom % 4);
      for (int b = 0; b < nb; b++) fill(b, 10 + ($urandom % 4));
      md = $urandom % 3;
      t = rand_word();
      if (md == 0) begin
        tw[nb-1][0] = 48'h999999999999;
        xb = m_fwd(t);
        run_op("R4 random", 0, 0, t, $urandom % 5, 1, xb, 0, 0);
      end else if (md == 1) begin
        tw[nb-1][0] = 48'h0;
        if (t == 48'h0) t = 48'h1;
        xb = m_rev(t);
        run_op("R5 random", 0, 1, t, $urandom % 5, 1, xb, 0, 0);
      end else begin
        tw[nb-1][$urandom % 10] = t;
        xb = m_scan(t);
        run_op("R6 random", 1, 1'($urandom % 2), t, $urandom % 5, 1, xb, 0, 0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule